// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block holds the two byte queues of a 16550-class serial port. One queue sits between the receive shifter and the host; the other sits between the host and the transmit shifter. A FIFO control register sets the operating mode, picks a receive trigger level and empties either queue on command. The block turns queue activity into one-cycle interrupt set and clear pulses for an interrupt controller placed elsewhere. It also builds the line status bits that depend on queue state.

In FIFO mode, a receive interrupt is requested only once the receive fill reaches the trigger level. A separate timeout request is raised when received data sits unread for four character times. The character-time strobe comes from the baud generator. In non-FIFO mode, every byte behaves like a single holding register for interrupt purposes. Parity, framing and break detection are handled elsewhere.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: While reset is held and right after it, all interrupt pulses are 0, `tx_valid_o` is 0, `rbr_rdata_o` is 0, FIFO mode is off and `lsr_o` reads 0x60.
- R2: Each queue is 16 bytes deep and first-in first-out. A write to a full queue is dropped. A host read of an empty receive queue returns 0 and changes nothing. `rbr_rdata_o` shows the oldest receive byte, or 0 when the queue is empty, in the cycle the read is presented.
- R3: A control write takes effect from the next cycle. Bit 0 turns FIFO mode on or off. Bits 7:6 set the receive trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14.
- R4: A control write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue. These bits are not stored. The emptying wins over a push or pop to the same queue in the same cycle, and that push or pop produces no interrupt pulse.
- R5: In non-FIFO mode, every accepted receive byte gives a one-cycle `irq_rx_set_o` pulse in the cycle after the byte is accepted.
- R6: In FIFO mode, an accepted receive byte pulses `irq_rx_set_o` one cycle later only if the fill after that cycle is at least the trigger level.
- R7: `irq_rx_clr_o` pulses one cycle after a host read that removes a byte. In FIFO mode this happens on every such read; in non-FIFO mode only when the read leaves the queue empty.
- R8: In FIFO mode, with the receive queue non-empty, four `char_tick_i` strobes with no receive push, host read or receive clear give one `irq_to_set_o` pulse in the cycle after the fourth strobe. No further pulse follows until the count restarts. Any of those three events, an empty queue, or non-FIFO mode restarts the count.
- R9: `irq_tx_set_o` pulses one cycle after a byte leaves the transmit queue. In FIFO mode this happens only when that byte was the last one; in non-FIFO mode it happens for every byte.
- R10: `lsr_o` bit 0 is 1 when the receive queue is non-empty and bit 6 always reads 1. Bit 5 is 1 when the transmit queue is empty in FIFO mode, and when it holds fewer than 16 bytes in non-FIFO mode. All other bits are 0.
- R11: `tx_valid_o` is 1 when the transmit queue is non-empty and `tx_data_o` shows its oldest byte. A byte is removed on a cycle with `tx_valid_o` and `tx_ready_i` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcr_we_i | input | 1 | FIFO control register write strobe |
| fcr_wdata_i | input | 8 | FIFO control write data |
| thr_we_i | input | 1 | Host write into the transmit queue |
| thr_wdata_i | input | 8 | Host transmit byte |
| rbr_re_i | input | 1 | Host read from the receive queue |
| rbr_rdata_o | output | 8 | Oldest receive byte, 0 when empty |
| rx_valid_i | input | 1 | Byte strobe from the receive shifter |
| rx_data_i | input | 8 | Byte from the receive shifter |
| tx_valid_o | output | 1 | Transmit queue has a byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Transmit shifter takes the byte |
| char_tick_i | input | 1 | One pulse per character time |
| lsr_o | output | 8 | FIFO-dependent line status bits |
| irq_rx_set_o | output | 1 | Receive-data interrupt request pulse |
| irq_rx_clr_o | output | 1 | Receive-data interrupt clear pulse |
| irq_to_set_o | output | 1 | Receive timeout request pulse |
| irq_tx_set_o | output | 1 | Transmit-empty request pulse |

## Verification
`rbr_rdata_o`, `tx_valid_o` and `tx_data_o` follow the stored state through logic alone. The bench reads them in the same cycle the stimulus is presented, one nanosecond after driving on the falling edge. The interrupt pulses, the timeout pulse and `lsr_o` come out of registers or of updated queue state, so they are due in the cycle after the rising edge that takes the stimulus. The bench samples them one nanosecond after that edge. Its model advances at the same edge, so a pulse that comes a cycle early or late shows up as a mismatch.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int unsigned FCR_EN_BIT    = 0;
  localparam int unsigned FCR_RXCLR_BIT = 1;
  localparam int unsigned FCR_TXCLR_BIT = 2;
  localparam int unsigned FCR_TRIG_LSB  = 6;

  typedef struct packed {
    logic       en;
    logic [1:0] trig;
  } fifo_cfg_t;

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    cnt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             push_acc_o,
  output logic             pop_acc_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign push_acc_o = push_i && !full_o && !clr_i;
  assign pop_acc_o  = pop_i && !empty_o && !clr_i;
  assign head_o     = mem_q[rd_ptr_q];
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_acc_o) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_acc_o)  rd_ptr_q <= bump(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_acc_o) - CW'(pop_acc_o);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_acc_o) mem_q[wr_ptr_q] <= data_i;
  end

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int unsigned CHARS = 4,
  localparam int unsigned TW = $clog2(CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic fire_o
);

  logic [TW-1:0] cnt_q;
  logic          fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (restart_i || !arm_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (tick_i && !fired_q) begin
        if (cnt_q == TW'(CHARS - 1)) begin
          fire_o  <= 1'b1;
          fired_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned TO_CHARS = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fcr_we_i,
  input  logic [7:0]    fcr_wdata_i,
  input  logic          thr_we_i,
  input  logic [DW-1:0] thr_wdata_i,
  input  logic          rbr_re_i,
  output logic [DW-1:0] rbr_rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          char_tick_i,
  output logic [7:0]    lsr_o,
  output logic          irq_rx_set_o,
  output logic          irq_rx_clr_o,
  output logic          irq_to_set_o,
  output logic          irq_tx_set_o
);

  fifo_cfg_t cfg_q;

  logic rx_clr, tx_clr;
  assign rx_clr = fcr_we_i && fcr_wdata_i[FCR_RXCLR_BIT];
  assign tx_clr = fcr_we_i && fcr_wdata_i[FCR_TXCLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (fcr_we_i) cfg_q <= '{en:   fcr_wdata_i[FCR_EN_BIT],
                                  trig: fcr_wdata_i[FCR_TRIG_LSB+1:FCR_TRIG_LSB]};
  end

  // receive queue
  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_cnt, rx_cnt_nxt;
  logic          rx_empty, rx_full, rx_push_acc, rx_pop_acc;

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rx_clr),
    .push_i     (rx_valid_i),
    .data_i     (rx_data_i),
    .pop_i      (rbr_re_i),
    .head_o     (rx_head),
    .cnt_o      (rx_cnt),
    .empty_o    (rx_empty),
    .full_o     (rx_full),
    .push_acc_o (rx_push_acc),
    .pop_acc_o  (rx_pop_acc)
  );

  // transmit queue
  logic [DW-1:0] tx_head;
  logic [CW-1:0] tx_cnt, tx_cnt_nxt;
  logic          tx_empty, tx_full, tx_push_acc, tx_pop_acc;

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_tx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (tx_clr),
    .push_i     (thr_we_i),
    .data_i     (thr_wdata_i),
    .pop_i      (tx_ready_i),
    .head_o     (tx_head),
    .cnt_o      (tx_cnt),
    .empty_o    (tx_empty),
    .full_o     (tx_full),
    .push_acc_o (tx_push_acc),
    .pop_acc_o  (tx_pop_acc)
  );

  assign rx_cnt_nxt = rx_cnt + CW'(rx_push_acc) - CW'(rx_pop_acc);
  assign tx_cnt_nxt = tx_cnt + CW'(tx_push_acc) - CW'(tx_pop_acc);

  assign rbr_rdata_o = rx_empty ? '0 : rx_head;
  assign tx_valid_o  = !tx_empty;
  assign tx_data_o   = tx_head;

  logic rx_at_trig;
  assign rx_at_trig = (rx_cnt_nxt >= CW'(trig_bytes(cfg_q.trig)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_rx_set_o <= 1'b0;
      irq_rx_clr_o <= 1'b0;
      irq_tx_set_o <= 1'b0;
    end else begin
      irq_rx_set_o <= rx_push_acc && (!cfg_q.en || rx_at_trig);
      irq_rx_clr_o <= rx_pop_acc && (cfg_q.en || rx_cnt_nxt == '0);
      irq_tx_set_o <= tx_pop_acc && (!cfg_q.en || tx_cnt_nxt == '0);
    end
  end

  uart_rx_timeout #(.CHARS(TO_CHARS)) u_rx_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (cfg_q.en && !rx_empty),
    .restart_i (rx_push_acc || rx_pop_acc || rx_clr),
    .tick_i    (char_tick_i),
    .fire_o    (irq_to_set_o)
  );

  logic thr_room;
  assign thr_room = cfg_q.en ? tx_empty : !tx_full;
  assign lsr_o    = {1'b0, 1'b1, thr_room, 4'b0000, !rx_empty};

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          rbr_re_i,
  input logic          tx_ready_i,
  input logic          char_tick_i,
  input logic          tx_valid_o,
  input logic [7:0]    lsr_o,
  input logic          irq_rx_set_o,
  input logic          irq_rx_clr_o,
  input logic          irq_to_set_o,
  input logic          irq_tx_set_o,
  input logic          fifo_en_i,
  input logic [1:0]    trig_sel_i,
  input logic [CW-1:0] rx_cnt_i
);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= CW'(DEPTH));

  assert_rx_set_after_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_set_o |-> $past(rx_valid_i));

  assert_rx_set_at_trigger_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_rx_set_o && $past(fifo_en_i)) |-> (rx_cnt_i >= CW'(trig_bytes($past(trig_sel_i)))));

  assert_rx_clr_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_clr_o |-> $past(rbr_re_i));

  assert_timeout_needs_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_to_set_o |-> (lsr_o[0] && $past(char_tick_i) && $past(fifo_en_i)));

  assert_tx_set_drained_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_tx_set_o && $past(fifo_en_i)) |-> !tx_valid_o);

  assert_tx_set_after_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_set_o |-> $past(tx_ready_i && tx_valid_o));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rbr_re_i     (rbr_re_i),
  .tx_ready_i   (tx_ready_i),
  .char_tick_i  (char_tick_i),
  .tx_valid_o   (tx_valid_o),
  .lsr_o        (lsr_o),
  .irq_rx_set_o (irq_rx_set_o),
  .irq_rx_clr_o (irq_rx_clr_o),
  .irq_to_set_o (irq_to_set_o),
  .irq_tx_set_o (irq_tx_set_o),
  .fifo_en_i    (cfg_q.en),
  .trig_sel_i   (cfg_q.trig),
  .rx_cnt_i     (rx_cnt)
);

// File: tb/uart_fifo_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_test;

  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fcr_we_i = 0, thr_we_i = 0, rbr_re_i = 0, rx_valid_i = 0;
  logic       tx_ready_i = 0, char_tick_i = 0;
  logic [7:0] fcr_wdata_i = 0, thr_wdata_i = 0, rx_data_i = 0;
  logic [7:0] rbr_rdata_o, tx_data_o, lsr_o;
  logic       tx_valid_o, irq_rx_set_o, irq_rx_clr_o, irq_to_set_o, irq_tx_set_o;

  always #10 clk_i = ~clk_i;

  uart_fifo_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fcr_we_i(fcr_we_i), .fcr_wdata_i(fcr_wdata_i),
    .thr_we_i(thr_we_i), .thr_wdata_i(thr_wdata_i),
    .rbr_re_i(rbr_re_i), .rbr_rdata_o(rbr_rdata_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .char_tick_i(char_tick_i), .lsr_o(lsr_o),
    .irq_rx_set_o(irq_rx_set_o), .irq_rx_clr_o(irq_rx_clr_o),
    .irq_to_set_o(irq_to_set_o), .irq_tx_set_o(irq_tx_set_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] rxq[$], txq[$];
  bit m_en = 0;
  bit [1:0] m_trg = 0;
  int m_to = 0;
  bit m_fired = 0;

  function automatic int trig_of(input bit [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic logic [7:0] exp_lsr();
    bit thre = m_en ? (txq.size() == 0) : (txq.size() < DEPTH);
    return {1'b0, 1'b1, thre, 4'b0, rxq.size() != 0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit fw, input logic [7:0] fd, input bit tw, input logic [7:0] td,
                     input bit rv, input logic [7:0] rd, input bit rr, input bit tr, input bit tk);
    bit clr_r, clr_t, rpush, rpop, tpush, tpop, arm, e_rs, e_rc, e_to, e_ts;
    int rn, tn;
    @(negedge clk_i);
    fcr_we_i = fw; fcr_wdata_i = fd; thr_we_i = tw; thr_wdata_i = td;
    rx_valid_i = rv; rx_data_i = rd; rbr_re_i = rr; tx_ready_i = tr; char_tick_i = tk;
    #1;
    chk("R2 rdata", rbr_rdata_o, rxq.size() ? rxq[0] : 8'h00);
    chk("R11 tx_valid", tx_valid_o, txq.size() != 0);
    if (txq.size()) chk("R11 tx_data", tx_data_o, txq[0]);
    clr_r = fw && fd[1];
    clr_t = fw && fd[2];
    rpush = rv && rxq.size() < DEPTH && !clr_r;
    rpop  = rr && rxq.size() > 0 && !clr_r;
    tpush = tw && txq.size() < DEPTH && !clr_t;
    tpop  = tr && txq.size() > 0 && !clr_t;
    rn = rxq.size() + rpush - rpop;
    tn = txq.size() + tpush - tpop;
    e_rs = rpush && (!m_en || rn >= trig_of(m_trg));
    e_rc = rpop && (m_en || rn == 0);
    e_ts = tpop && (!m_en || tn == 0);
    arm = m_en && rxq.size() > 0;
    e_to = 0;
    if (!arm || rpush || rpop || clr_r) begin
      m_to = 0; m_fired = 0;
    end else if (tk && !m_fired) begin
      if (m_to == 3) begin e_to = 1; m_fired = 1; end
      else m_to++;
    end
    if (clr_r) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rd);
    end
    if (clr_t) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(td);
    end
    if (fw) begin m_en = fd[0]; m_trg = fd[7:6]; end
    @(posedge clk_i);
    #1;
    chk(e_rs && m_en ? "R6 rx_set" : "R5 rx_set", irq_rx_set_o, e_rs);
    chk("R7 rx_clr", irq_rx_clr_o, e_rc);
    chk("R8 timeout", irq_to_set_o, e_to);
    chk("R9 tx_set", irq_tx_set_o, e_ts);
    chk("R10 lsr", lsr_o, exp_lsr());
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'h5eed_1234));
    #35;
    chk("R1 lsr in reset", lsr_o, 8'h60);
    chk("R1 tx_valid in reset", tx_valid_o, 0);
    chk("R1 rdata in reset", rbr_rdata_o, 0);
    chk("R1 pulses in reset", {irq_rx_set_o, irq_rx_clr_o, irq_to_set_o, irq_tx_set_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle();
    chk("R1 lsr after reset", lsr_o, 8'h60);

    // non-FIFO mode receive
    cyc(0, 0, 0, 0, 1, 8'hA5, 0, 0, 0);
    chk("R5 pulse on byte", irq_rx_set_o, 1);
    cyc(0, 0, 0, 0, 1, 8'h5A, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 clr when empty non-FIFO", irq_rx_clr_o, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R2 empty read keeps lsr", lsr_o[0], 0);

    // trigger levels
    for (int s = 0; s < 4; s++) begin
      cyc(1, 8'(s << 6) | 8'h03, 0, 0, 0, 0, 0, 0, 0);
      pulses = 0;
      for (int k = 0; k < trig_of(2'(s)); k++) begin
        cyc(0, 0, 0, 0, 1, 8'(k + 16 * s), 0, 0, 0);
        pulses += irq_rx_set_o;
      end
      chk("R3 R6 one pulse at trigger", pulses, 1);
      chk("R6 pulse on trigger byte", irq_rx_set_o, 1);
    end

    // overflow then drain past empty
    cyc(1, 8'hC3, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < DEPTH + 2; k++) cyc(0, 0, 0, 0, 1, 8'(k + 1), 0, 0, 0);
    for (int k = 0; k < DEPTH + 2; k++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R2 last read of empty", rbr_rdata_o, 0);

    // timeout
    cyc(0, 0, 0, 0, 1, 8'h77, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 pulse after fourth tick", irq_to_set_o, 1);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 no repeat", irq_to_set_o, 0);

    // transmit drain in FIFO mode
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 8'(8'h40 + k), 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 set on last byte", irq_tx_set_o, 1);

    // clear priority
    cyc(0, 0, 1, 8'h11, 1, 8'h22, 0, 0, 0);
    cyc(1, 8'h07, 1, 8'h33, 1, 8'h44, 0, 0, 0);
    chk("R4 rx emptied", lsr_o[0], 0);
    chk("R4 tx emptied", tx_valid_o, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit fw = ($urandom % 100) < 2;
      logic [7:0] fd = {2'($urandom), 3'b0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                        ($urandom % 10) != 0};
      cyc(fw, fd, ($urandom % 10) < 3, 8'($urandom), ($urandom % 10) < 3, 8'($urandom),
          ($urandom % 10) < 3, ($urandom % 10) < 3, ($urandom % 10) < 3);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule